// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block draws a 64 by 64 pixel monochrome pointer over a 32-bit-per-pixel video stream. Each incoming beat carries the screen line, the screen column and the pixel already composed from the frame buffer. When the beat falls inside the cursor window, the block reads that cursor row from a small synchronous mask memory and picks one pixel action from the two mask bits. The pixel can stay transparent, take one of two programmable colours, or take the inverse of the screen pixel. Drawing is clipped at the right edge of the visible line.

Software programs a small register file with the enable, the position, a hotspot value, the mask base address, the two colours and the horizontal display field. A lock bit keeps a half-updated position or base away from the screen. Both stream interfaces use valid/ready. A beat moves on any cycle where valid and ready are both high. When the output is valid and `out_ready` is low, the whole two-stage pipeline stalls: `in_ready` drops and `out_pix` holds its value. The mask memory is read only when an input beat is accepted, and it must hold its read data while it is not read.

Top module: `cursor_overlay`

## Requirements
- R1: With `out_ready` held high, a beat accepted in cycle c appears on `out_valid`/`out_pix` in cycle c+2 and not in cycle c+1. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_pix` stays constant.
- R2: Cursor row r (0..63) is the memory word at address BASE[MEM_AW+3:4] + r. The AND mask byte i (i = 0..7) is in data bits [8i+7:8i], and the XOR mask byte i is in bits [64+8i+7:64+8i].
- R3: Within a row, cursor column k uses bit 7-(k mod 8) of mask byte k/8, so the most significant bit is used first.
- R4: If AND=1 and XOR=1, the output is the bitwise inverse of the input pixel. If AND=1 and XOR=0, the input pixel passes through unchanged.
- R5: If AND=0, the output is {COLOR1[23:0], 8'hFF} when XOR=1 and {COLOR0[23:0], 8'hFF} when XOR=0.
- R6: POS holds X in bits [29:16] and Y in bits [11:0]. The cursor affects only lines Y..Y+63 and columns X..X+63. All other beats pass through.
- R7: When CTRL bit 0 (enable) is 0, every beat passes through unchanged.
- R8: A cursor pixel whose column is at or beyond (HDISP[10:0]+1)*8 is not drawn, and the input pixel passes through.
- R9: Bit 31 of BASE is the lock. While the lock is set, new values written to POS or BASE do not move the drawn cursor. The pending values take effect once the lock clears.
- R10: A write to POS or HOTSPOT sets the lock when data bit 31 is 1 and clears it when bit 31 is 0. Reads of POS and HOTSPOT return the lock in bit 31.
- R11: BASE keeps only the bits under mask 0x87FFFFF0. HOTSPOT keeps bits under 0x003F003F, POS under 0x3FFF0FFF, the colours under 0x00FFFFFF and HDISP bits [10:0].
- R12: Register addresses are CTRL=0, POS=1, HOTSPOT=2, BASE=3, COLOR0=4, COLOR1=5, HDISP=6. After reset every register reads 0, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_line | input | 12 | Screen line of the beat |
| in_col | input | 14 | Screen column of the beat |
| in_pix | input | 32 | Underlying screen pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output beat |
| out_pix | output | 32 | Composited pixel |
| mem_rd_en | output | 1 | Mask memory read enable |
| mem_addr | output | MEM_AW | Mask memory word address |
| mem_rdata | input | 128 | Mask memory data, one cycle after the read |

## Verification
The assertions assume that the mask memory returns data one cycle after `mem_rd_en` and keeps its output while not read. They also assume that `reg_wr` and `reg_addr` are clean at clock edges. The bench's memory model has exactly this read behaviour, and it drives every input at the falling edge. The pipeline-hold property assumes the downstream side may keep `out_ready` low for any number of cycles. The bench stalls for several cycles while the upstream side offers no new beat.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int XW        = 14;   // screen column / cursor X width
  localparam int YW        = 12;   // screen line / cursor Y width
  localparam int HW        = 11;   // horizontal display field width
  localparam int CDIM_LG   = 6;    // log2 of cursor side (64)
  localparam int MBYTES    = 8;    // mask bytes per plane per row
  localparam int ROW_BITS  = 2 * MBYTES * 8;
  localparam int PIX_W     = 32;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_POS   = 3'd1,
    RA_HOT   = 3'd2,
    RA_BASE  = 3'd3,
    RA_CLR0  = 3'd4,
    RA_CLR1  = 3'd5,
    RA_HDISP = 3'd6
  } reg_addr_e;

  localparam logic [31:0] POS_MASK  = 32'h3FFF_0FFF;
  localparam logic [31:0] HOT_MASK  = 32'h003F_003F;
  localparam logic [31:0] BASE_MASK = 32'h87FF_FFF0;
  localparam logic [31:0] CLR_MASK  = 32'h00FF_FFFF;

  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_CLR0 = 2'd1,
    ACT_CLR1 = 2'd2,
    ACT_INV  = 2'd3
  } pix_action_e;

  typedef struct packed {
    logic                 hit;
    logic [CDIM_LG-1:0]   cx;
    logic [PIX_W-1:0]     pix;
  } stage1_t;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              enable,
  output logic              lock,
  output logic [XW-1:0]     act_x,
  output logic [YW-1:0]     act_y,
  output logic [MEM_AW-1:0] act_word,
  output logic [23:0]       color0,
  output logic [23:0]       color1,
  output logic [HW-1:0]     hdisp
);
  logic              ctrl_q;
  logic [31:0]       pos_q;
  logic [31:0]       hot_q;
  logic [31:0]       base_q;
  logic [23:0]       clr0_q, clr1_q;
  logic [HW-1:0]     hdisp_q;
  logic [XW-1:0]     act_x_q;
  logic [YW-1:0]     act_y_q;
  logic [MEM_AW-1:0] act_word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= 1'b0;
      pos_q   <= '0;
      hot_q   <= '0;
      base_q  <= '0;
      clr0_q  <= '0;
      clr1_q  <= '0;
      hdisp_q <= '0;
    end else if (wr) begin
      case (addr)
        RA_CTRL:  ctrl_q <= wdata[0];
        RA_POS: begin
          pos_q      <= wdata & POS_MASK;
          base_q[31] <= wdata[31];
        end
        RA_HOT: begin
          hot_q      <= wdata & HOT_MASK;
          base_q[31] <= wdata[31];
        end
        RA_BASE:  base_q  <= wdata & BASE_MASK;
        RA_CLR0:  clr0_q  <= wdata[23:0];
        RA_CLR1:  clr1_q  <= wdata[23:0];
        RA_HDISP: hdisp_q <= wdata[HW-1:0];
        default: ;
      endcase
    end
  end

  // Displayed copies follow the programmed values only while unlocked.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_x_q    <= '0;
      act_y_q    <= '0;
      act_word_q <= '0;
    end else if (!base_q[31]) begin
      act_x_q    <= pos_q[16 +: XW];
      act_y_q    <= pos_q[YW-1:0];
      act_word_q <= base_q[MEM_AW+3:4];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL:  rdata = {31'd0, ctrl_q};
      RA_POS:   rdata = pos_q | {base_q[31], 31'd0};
      RA_HOT:   rdata = hot_q | {base_q[31], 31'd0};
      RA_BASE:  rdata = base_q;
      RA_CLR0:  rdata = {8'd0, clr0_q};
      RA_CLR1:  rdata = {8'd0, clr1_q};
      RA_HDISP: rdata = {{(32-HW){1'b0}}, hdisp_q};
      default:  rdata = '0;
    endcase
  end

  assign enable   = ctrl_q;
  assign lock     = base_q[31];
  assign act_x    = act_x_q;
  assign act_y    = act_y_q;
  assign act_word = act_word_q;
  assign color0   = clr0_q;
  assign color1   = clr1_q;
  assign hdisp    = hdisp_q;
endmodule

// File: rtl/cursor_locate.sv
module cursor_locate
  import cursor_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic [YW-1:0]      line,
  input  logic [XW-1:0]      col,
  input  logic [XW-1:0]      cur_x,
  input  logic [YW-1:0]      cur_y,
  input  logic [HW-1:0]      hdisp,
  input  logic               enable,
  input  logic [MEM_AW-1:0]  base_word,
  output logic               hit,
  output logic [CDIM_LG-1:0] cx,
  output logic [MEM_AW-1:0]  rd_addr
);
  logic [YW:0] dy;
  logic [XW:0] dx;
  logic [XW:0] width;
  logic        in_rows, in_cols, in_view;

  always_comb begin
    dy      = {1'b0, line} - {1'b0, cur_y};
    dx      = {1'b0, col}  - {1'b0, cur_x};
    in_rows = !dy[YW] && (dy[YW-1:CDIM_LG] == '0);
    in_cols = !dx[XW] && (dx[XW-1:CDIM_LG] == '0);
    width   = ({{(XW+1-HW){1'b0}}, hdisp} + 1'b1) << 3;
    in_view = ({1'b0, col} < width);
    hit     = enable && in_rows && in_cols && in_view;
    cx      = dx[CDIM_LG-1:0];
    rd_addr = base_word + MEM_AW'(dy[CDIM_LG-1:0]);
  end
endmodule

// File: rtl/cursor_blend.sv
module cursor_blend
  import cursor_pkg::*;
(
  input  logic                hit,
  input  logic [CDIM_LG-1:0]  cx,
  input  logic [ROW_BITS-1:0] row,
  input  logic [PIX_W-1:0]    pix,
  input  logic [23:0]         color0,
  input  logic [23:0]         color1,
  output logic [PIX_W-1:0]    out
);
  logic [7:0] and_b [MBYTES];
  logic [7:0] xor_b [MBYTES];

  for (genvar g = 0; g < MBYTES; g++) begin : g_lane
    assign and_b[g] = row[8*g +: 8];
    assign xor_b[g] = row[8*MBYTES + 8*g +: 8];
  end

  logic [2:0]  sel;
  logic [2:0]  bitn;
  logic        a_bit, x_bit;
  pix_action_e act;

  always_comb begin
    sel   = cx[5:3];
    bitn  = 3'd7 - cx[2:0];
    a_bit = and_b[sel][bitn];
    x_bit = xor_b[sel][bitn];
    if (!hit)        act = ACT_PASS;
    else if (a_bit)  act = x_bit ? ACT_INV : ACT_PASS;
    else             act = x_bit ? ACT_CLR1 : ACT_CLR0;
    case (act)
      ACT_INV:  out = ~pix;
      ACT_CLR0: out = {color0, 8'hFF};
      ACT_CLR1: out = {color1, 8'hFF};
      default:  out = pix;
    endcase
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [YW-1:0]       in_line,
  input  logic [XW-1:0]       in_col,
  input  logic [PIX_W-1:0]    in_pix,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PIX_W-1:0]    out_pix,
  output logic                mem_rd_en,
  output logic [MEM_AW-1:0]   mem_addr,
  input  logic [ROW_BITS-1:0] mem_rdata
);
  logic              enable, lock_q;
  logic [XW-1:0]     act_x;
  logic [YW-1:0]     act_y;
  logic [MEM_AW-1:0] act_word;
  logic [23:0]       color0, color1;
  logic [HW-1:0]     hdisp;

  cursor_regs #(.MEM_AW(MEM_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .enable(enable), .lock(lock_q),
    .act_x(act_x), .act_y(act_y), .act_word(act_word),
    .color0(color0), .color1(color1), .hdisp(hdisp)
  );

  logic               hit0;
  logic [CDIM_LG-1:0] cx0;
  logic [MEM_AW-1:0]  rd_addr;

  cursor_locate #(.MEM_AW(MEM_AW)) u_loc (
    .line(in_line), .col(in_col), .cur_x(act_x), .cur_y(act_y),
    .hdisp(hdisp), .enable(enable), .base_word(act_word),
    .hit(hit0), .cx(cx0), .rd_addr(rd_addr)
  );

  logic    adv, accept;
  logic    s1_valid;
  stage1_t s1;
  logic [PIX_W-1:0] blended;

  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;
  assign accept    = in_valid && adv;
  assign mem_rd_en = accept;
  assign mem_addr  = rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1       <= '0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) s1 <= '{hit: hit0, cx: cx0, pix: in_pix};
    end
  end

  cursor_blend u_blend (
    .hit(s1.hit), .cx(s1.cx), .row(mem_rdata), .pix(s1.pix),
    .color0(color0), .color1(color1), .out(blended)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) out_pix <= blended;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic             s1_valid,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             lock_q,
  input logic [XW-1:0]    act_x,
  input logic [YW-1:0]    act_y
);
  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  assert_stall_noaccept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_accept_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(act_x) && $stable(act_y));

  assert_lock_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == RA_POS || reg_addr == RA_HOT) && reg_wdata[31] |=> lock_q);

  assert_lock_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == RA_POS || reg_addr == RA_HOT) && !reg_wdata[31] |=> !lock_q);
endmodule

bind cursor_overlay cursor_overlay_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
  .s1_valid(s1_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .lock_q(lock_q), .act_x(act_x), .act_y(act_y)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
  localparam int MEM_AW = 8;
  localparam logic [23:0] C0 = 24'h123456;
  localparam logic [23:0] C1 = 24'hABCDEF;
  localparam int NV = 16;
  // {4'h0, line[11:0], col[13:0], kind[1:0]}; kind 0 pass,1 colour0,2 colour1,3 invert
  localparam logic [31:0] VEC [NV] = '{
    {4'h0, 12'd50,  14'd100, 2'd3},
    {4'h0, 12'd50,  14'd101, 2'd0},
    {4'h0, 12'd50,  14'd102, 2'd2},
    {4'h0, 12'd50,  14'd103, 2'd1},
    {4'h0, 12'd49,  14'd100, 2'd0},
    {4'h0, 12'd114, 14'd100, 2'd0},
    {4'h0, 12'd113, 14'd104, 2'd3},
    {4'h0, 12'd55,  14'd116, 2'd2},
    {4'h0, 12'd55,  14'd117, 2'd2},
    {4'h0, 12'd55,  14'd124, 2'd3},
    {4'h0, 12'd113, 14'd156, 2'd1},
    {4'h0, 12'd113, 14'd163, 2'd1},
    {4'h0, 12'd50,  14'd99,  2'd0},
    {4'h0, 12'd50,  14'd164, 2'd0},
    {4'h0, 12'd80,  14'd131, 2'd1},
    {4'h0, 12'd55,  14'd123, 2'd2}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [11:0]  in_line = '0;
  logic [13:0]  in_col = '0;
  logic [31:0]  in_pix = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  out_pix;
  logic         mem_rd_en;
  logic [MEM_AW-1:0] mem_addr;
  logic [127:0] mem_rdata = '0;
  logic [127:0] mem [1<<MEM_AW];

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  cursor_overlay #(.MEM_AW(MEM_AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_line(in_line), .in_col(in_col), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] expect_pix(input logic [1:0] kind, input logic [31:0] p);
    case (kind)
      2'd1: return {C0, 8'hFF};
      2'd2: return {C1, 8'hFF};
      2'd3: return ~p;
      default: return p;
    endcase
  endfunction

  // Drives one beat and returns the result sampled two cycles later (R1).
  task automatic send(input string req, input logic [11:0] ln, input logic [13:0] cl,
                      input logic [31:0] px, input logic [31:0] exp);
    logic early;
    @(negedge clk);
    in_valid = 1'b1; in_line = ln; in_col = cl; in_pix = px;
    @(negedge clk);
    in_valid = 1'b0;
    early = out_valid;
    @(negedge clk);
    chk("R1 latency", {30'd0, early, out_valid}, 32'd1);
    chk(req, out_pix, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] hold;
    for (int w = 0; w < (1 << MEM_AW); w++) mem[w] = '0;
    for (int row = 0; row < 64; row++) begin
      mem[16 + row] = {{8{8'hAA}}, {8{8'hCC}}};
    end
    mem[16 + 5][23:16]   = 8'h00;
    mem[16 + 5][87:80]   = 8'hFF;
    mem[16 + 63][63:56]  = 8'h00;
    mem[16 + 63][127:120] = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12: reset state
    @(negedge clk);
    chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R12 in_ready", {31'd0, in_ready}, 32'd1);
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], r);
      chk("R12 reg reset", r, 32'd0);
    end

    wr(3'd0, 32'd1);
    wr(3'd1, (32'd100 << 16) | 32'd50);
    wr(3'd3, 32'h0000_0100);
    wr(3'd4, {8'h77, C0});
    wr(3'd5, {8'h99, C1});
    wr(3'd6, 32'd79);
    rd(3'd4, r);
    chk("R11 colour mask", r, {8'd0, C0});

    // Table: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [31:0] px;
      px = 32'hA5C3_0F00 + i * 32'h0001_0203;
      send($sformatf("R2/R3/R4/R5/R6 vector %0d", i), VEC[i][27:16], VEC[i][15:2],
           px, expect_pix(VEC[i][1:0], px));
    end

    // R11: base mask (sets lock too), then restore
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, r);
    chk("R11 base mask", r, 32'h87FF_FFF0);
    wr(3'd3, 32'h0000_0100);

    // R9/R10: lock through POS
    wr(3'd1, 32'h8000_0000 | (32'd300 << 16) | 32'd50);
    rd(3'd1, r);
    chk("R10 pos read lock", r, 32'h8000_0000 | (32'd300 << 16) | 32'd50);
    rd(3'd3, r);
    chk("R10 base lock bit", r, 32'h8000_0100);
    wr(3'd3, 32'h8000_0200);
    send("R9 locked pos/base held", 12'd50, 14'd100, 32'h0F0F_3C3C, 32'hF0F0_C3C3);
    wr(3'd3, 32'h0000_0100);
    send("R9 released old pos", 12'd50, 14'd100, 32'h0F0F_3C3C, 32'h0F0F_3C3C);
    send("R9 released new pos", 12'd50, 14'd300, 32'h0F0F_3C3C, 32'hF0F0_C3C3);
    wr(3'd1, (32'd100 << 16) | 32'd50);
    rd(3'd1, r);
    chk("R10 pos unlocked read", r, (32'd100 << 16) | 32'd50);

    // R10/R11: lock through HOTSPOT
    wr(3'd2, 32'h80FF_00FF);
    rd(3'd2, r);
    chk("R10 hotspot lock+mask", r, 32'h803F_003F);
    wr(3'd2, 32'h0000_0000);
    rd(3'd3, r);
    chk("R10 hotspot unlock", r, 32'h0000_0100);

    // R7: enable off
    wr(3'd0, 32'd0);
    send("R7 disabled pass", 12'd50, 14'd100, 32'h1234_5678, 32'h1234_5678);
    wr(3'd0, 32'd1);

    // R8: right edge clip at 640
    wr(3'd1, (32'd620 << 16) | 32'd50);
    send("R8 inside edge invert", 12'd50, 14'd636, 32'h0000_FFFF, 32'hFFFF_0000);
    send("R8 last column drawn", 12'd50, 14'd639, 32'h0000_FFFF, {C0, 8'hFF});
    send("R8 clipped at width", 12'd50, 14'd640, 32'h0000_FFFF, 32'h0000_FFFF);
    // R8: narrow width 80
    wr(3'd6, 32'd9);
    wr(3'd1, (32'd70 << 16) | 32'd50);
    send("R8 narrow drawn", 12'd50, 14'd78, 32'h00FF_00FF, 32'hFF00_FF00);
    send("R8 narrow clipped", 12'd50, 14'd80, 32'h00FF_00FF, 32'h00FF_00FF);
    wr(3'd6, 32'd79);
    wr(3'd1, (32'd100 << 16) | 32'd50);

    // R1: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_line = 12'd50; in_col = 14'd102; in_pix = 32'h5555_5555;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    hold = out_pix;
    chk("R1 stall valid", {31'd0, out_valid}, 32'd1);
    chk("R1 stall pixel", hold, {C1, 8'hFF});
    repeat (3) @(negedge clk);
    chk("R1 stall hold", out_pix, hold);
    chk("R1 stall in_ready", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R1 drained", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule